// File: doc/BRIEF.md
# Four-Strike Watchdog Timer

This block is a watchdog that counts down a programmable number of microsecond ticks. Each time the countdown runs out it reloads from the programmed period and advances a small expiration counter. The first expiration can raise an interrupt. The fourth expiration in a row raises a system reset request. Software keeps the system alive by issuing a start command again before the fourth expiration. That command reloads the countdown, clears the expiration count and clears the interrupt.

The ticks come from a companion one-microsecond timer inside the block. A free-running prescaler divides the core clock down to a one-microsecond strobe. A reloadable timer counts those strobes and emits a tick every `reload` microseconds. The timer runs either once or with automatic reload. Stopping the watchdog is guarded: a stop command is obeyed only when the matching key was written to the key register since the previous command write.

All registers sit on a simple word-wide write port and a combinational read port. Both ports use byte offsets: settings at 0x0, status at 0x4, command at 0x8, key at 0xC and the tick timer at 0x10.

Top module: `expiry_watchdog`

## Requirements
- R1: The settings register at offset 0x0 stores the period in bits [11:4], the interrupt enable in bit 12 and the reset-request enable in bit 15. A read returns those bits and zero elsewhere.
- R2: The status register at offset 0x4 returns the live countdown in bits [11:4] and the expiration count in bits [13:12], with zero elsewhere.
- R3: Writing the command register (0x8) with bit 0 set starts the watchdog, or restarts it if it is already running. The countdown loads the period, the expiration count becomes 0 and the interrupt output drops on the next clock.
- R4: While the watchdog runs, each tick lowers the countdown by one. On a tick that finds the countdown at 1, the countdown reloads the period and the expiration count rises by one, wrapping from 3 to 0.
- R5: A period of 0 behaves as a period of 1. A running countdown is never 0.
- R6: The interrupt output rises on an expiration that takes the count from 0 to 1, provided the interrupt enable is set. It stays high until a start or an accepted stop command. With the enable clear it never rises.
- R7: The reset request rises on the expiration that takes the count from 3 to 0, provided the reset enable is set, and never earlier. Once high it stays high until the asynchronous block reset.
- R8: Command bit 1 (stop) halts the watchdog and clears the interrupt only if the last write to the key register (0xC) carried 0xC45A in bits [15:0] and no command write has happened since. A key write of any other value, or any command write, withdraws the permission. When bits 0 and 1 are both set and permission holds, the stop wins. A halted watchdog keeps its countdown and expiration count frozen.
- R9: The tick timer register at 0x10 holds the enable in bit 31, the auto-reload flag in bit 30 and the reload value in the low bits. Writing it loads the timer. While enabled, the timer emits one tick every max(reload,1) microsecond strobes. In single-shot mode it clears its own enable bit after its tick. The register reads back its current state.
- R10: The microsecond strobe occurs once every CLK_PER_US core clock cycles, so a window of k*CLK_PER_US cycles holds exactly k strobes.
- R11: After the asynchronous reset every register reads zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Byte offset of the register written |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Byte offset of the register read |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Level interrupt on the first expiration |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The main instance is built with CLK_PER_US = 1, so the strobe fires on every clock. A single-shot timer write with reload 1 then yields exactly one tick. This lets the vector walk step the countdown one tick at a time and read the status at exact points: across all four expirations, the period-zero case and every key and command ordering. The same instance also checks a reload of 3 to the cycle and an auto-reload run of eight ticks. A second instance, built with CLK_PER_US = 3, runs auto-reload for thirty clocks. It must end exactly ten counts lower whatever the prescaler phase.

// File: rtl/ewd_pkg.sv
package ewd_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned PER_W  = 8;

    // register byte offsets
    localparam logic [7:0] OFS_CFG = 8'h00;
    localparam logic [7:0] OFS_STS = 8'h04;
    localparam logic [7:0] OFS_CMD = 8'h08;
    localparam logic [7:0] OFS_KEY = 8'h0C;
    localparam logic [7:0] OFS_TMR = 8'h10;

    // field positions decoded by software
    localparam int unsigned PER_LSB      = 4;
    localparam int unsigned IRQ_EN_BIT   = 12;
    localparam int unsigned RST_EN_BIT   = 15;
    localparam int unsigned EXP_LSB      = 12;
    localparam int unsigned GO_BIT       = 0;
    localparam int unsigned HALT_BIT     = 1;
    localparam int unsigned TMR_EN_BIT   = 31;
    localparam int unsigned TMR_AUTO_BIT = 30;

    localparam logic [15:0] KEY_VALUE = 16'hC45A;

    typedef struct packed {
        logic [PER_W-1:0] period;
        logic             irq_en;
        logic             rst_en;
    } cfg_t;

endpackage

// File: rtl/ewd_tick_gen.sv
module ewd_tick_gen
    import ewd_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 100,
    parameter int unsigned RELOAD_W   = 30
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_data_i,
    output logic              tick_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int unsigned PS_W   = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(CLK_PER_US - 1);

    typedef struct packed {
        logic [PS_W-1:0]     ps;
        logic                en;
        logic                auto_rl;
        logic [RELOAD_W-1:0] reload;
        logic [RELOAD_W-1:0] cnt;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic      us_strobe;

    always_comb begin
        st_d      = st_q;
        us_strobe = (st_q.ps == PS_LAST);
        tick_o    = 1'b0;

        if (us_strobe) begin
            st_d.ps = '0;
        end else begin
            st_d.ps = st_q.ps + 1'b1;
        end

        if (st_q.en && us_strobe) begin
            if (st_q.cnt <= RELOAD_W'(1)) begin
                tick_o   = 1'b1;
                st_d.cnt = st_q.reload;
                if (!st_q.auto_rl) begin
                    st_d.en = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        if (load_i) begin
            st_d.en      = load_data_i[TMR_EN_BIT];
            st_d.auto_rl = load_data_i[TMR_AUTO_BIT];
            st_d.reload  = load_data_i[RELOAD_W-1:0];
            st_d.cnt     = load_data_i[RELOAD_W-1:0];
        end
    end

    always_comb begin
        word_o               = '0;
        word_o[TMR_EN_BIT]   = st_q.en;
        word_o[TMR_AUTO_BIT] = st_q.auto_rl;
        word_o[RELOAD_W-1:0] = st_q.reload;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ewd_regs.sv
module ewd_regs
    import ewd_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output cfg_t              cfg_o,
    output logic              go_o,
    output logic              halt_o,
    output logic              tmr_load_o
);

    typedef struct packed {
        cfg_t cfg;
        logic armed;
    } rg_state_t;

    rg_state_t st_d, st_q;
    logic      hit_cfg, hit_cmd, hit_key;

    always_comb begin
        st_d       = st_q;
        hit_cfg    = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CFG));
        hit_cmd    = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CMD));
        hit_key    = wr_en_i && (wr_addr_i == ADDR_W'(OFS_KEY));
        tmr_load_o = wr_en_i && (wr_addr_i == ADDR_W'(OFS_TMR));
        go_o       = hit_cmd && wr_data_i[GO_BIT];
        halt_o     = hit_cmd && wr_data_i[HALT_BIT] && st_q.armed;

        if (hit_cfg) begin
            st_d.cfg.period = wr_data_i[PER_LSB +: PER_W];
            st_d.cfg.irq_en = wr_data_i[IRQ_EN_BIT];
            st_d.cfg.rst_en = wr_data_i[RST_EN_BIT];
        end
        if (hit_key) begin
            st_d.armed = (wr_data_i[15:0] == KEY_VALUE);
        end
        if (hit_cmd) begin
            st_d.armed = 1'b0;
        end
    end

    assign cfg_o = st_q.cfg;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ewd_countdown.sv
module ewd_countdown
    import ewd_pkg::*;
#(
    parameter int unsigned EXP_COUNT = 4
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         tick_i,
    input  logic                         go_i,
    input  logic                         halt_i,
    input  cfg_t                         cfg_i,
    output logic                         run_o,
    output logic [PER_W-1:0]             cnt_o,
    output logic [$clog2(EXP_COUNT)-1:0] exp_o,
    output logic                         irq_o,
    output logic                         rst_req_o
);

    localparam int unsigned EXP_W = $clog2(EXP_COUNT);
    localparam logic [EXP_W-1:0] EXP_LAST = EXP_W'(EXP_COUNT - 1);

    typedef struct packed {
        logic             run;
        logic [PER_W-1:0] cnt;
        logic [EXP_W-1:0] exp;
        logic             irq;
        logic             rst;
    } wd_state_t;

    wd_state_t        st_d, st_q;
    logic [PER_W-1:0] per_eff;

    always_comb begin
        st_d    = st_q;
        per_eff = (cfg_i.period == '0) ? PER_W'(1) : cfg_i.period;

        if (st_q.run && tick_i) begin
            if (st_q.cnt <= PER_W'(1)) begin
                st_d.cnt = per_eff;
                st_d.exp = st_q.exp + 1'b1;
                if ((st_q.exp == '0) && cfg_i.irq_en) begin
                    st_d.irq = 1'b1;
                end
                if ((st_q.exp == EXP_LAST) && cfg_i.rst_en) begin
                    st_d.rst = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        if (halt_i) begin
            st_d.run = 1'b0;
            st_d.irq = 1'b0;
        end else if (go_i) begin
            st_d.run = 1'b1;
            st_d.cnt = per_eff;
            st_d.exp = '0;
            st_d.irq = 1'b0;
        end
    end

    assign run_o     = st_q.run;
    assign cnt_o     = st_q.cnt;
    assign exp_o     = st_q.exp;
    assign irq_o     = st_q.irq;
    assign rst_req_o = st_q.rst;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/expiry_watchdog.sv
module expiry_watchdog
    import ewd_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 100,
    parameter int unsigned RELOAD_W   = 30,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned EXP_COUNT  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rd_data_o,
    output logic              irq_o,
    output logic              rst_req_o
);

    localparam int unsigned EXP_W = $clog2(EXP_COUNT);

    cfg_t              cfg;
    logic              go, halt, tmr_load, tick;
    logic              wd_run;
    logic [PER_W-1:0]  wd_cnt;
    logic [EXP_W-1:0]  wd_exp;
    logic [WORD_W-1:0] tmr_word, cfg_word, sts_word;

    ewd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .cfg_o      (cfg),
        .go_o       (go),
        .halt_o     (halt),
        .tmr_load_o (tmr_load)
    );

    ewd_tick_gen #(.CLK_PER_US(CLK_PER_US), .RELOAD_W(RELOAD_W)) u_tick (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (tmr_load),
        .load_data_i (wr_data_i),
        .tick_o      (tick),
        .word_o      (tmr_word)
    );

    ewd_countdown #(.EXP_COUNT(EXP_COUNT)) u_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .go_i      (go),
        .halt_i    (halt),
        .cfg_i     (cfg),
        .run_o     (wd_run),
        .cnt_o     (wd_cnt),
        .exp_o     (wd_exp),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    always_comb begin
        cfg_word                     = '0;
        cfg_word[PER_LSB +: PER_W]   = cfg.period;
        cfg_word[IRQ_EN_BIT]         = cfg.irq_en;
        cfg_word[RST_EN_BIT]         = cfg.rst_en;
        sts_word                     = '0;
        sts_word[PER_LSB +: PER_W]   = wd_cnt;
        sts_word[EXP_LSB +: EXP_W]   = wd_exp;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(OFS_CFG)) begin
            rd_data_o = cfg_word;
        end else if (rd_addr_i == ADDR_W'(OFS_STS)) begin
            rd_data_o = sts_word;
        end else if (rd_addr_i == ADDR_W'(OFS_TMR)) begin
            rd_data_o = tmr_word;
        end
    end

endmodule

// File: rtl/ewd_checker.sv
module ewd_checker #(
    parameter int unsigned EXP_W = 2,
    parameter int unsigned PER_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             go,
    input logic             halt,
    input logic             tick,
    input logic             irq_en,
    input logic             wd_run,
    input logic [PER_W-1:0] wd_cnt,
    input logic [EXP_W-1:0] wd_exp,
    input logic             irq_o,
    input logic             rst_req_o
);

    AST_PING_CLEARS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go |=> !irq_o); // R3

    AST_CNT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wd_run && !tick && !go && !halt) |=> $stable(wd_cnt)); // R4

    AST_EXP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wd_run && !go) |=> ((wd_exp == $past(wd_exp)) || (wd_exp == EXP_W'($past(wd_exp) + 1'b1)))); // R4

    AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_run |-> (wd_cnt != '0)); // R5

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(irq_en)); // R6

    AST_RST_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_req_o) |-> ($past(wd_exp) == {EXP_W{1'b1}})); // R7

    AST_RST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> rst_req_o); // R7

    AST_HALT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt |=> !wd_run); // R8

endmodule

bind expiry_watchdog ewd_checker #(.EXP_W(EXP_W), .PER_W(ewd_pkg::PER_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go        (go),
    .halt      (halt),
    .tick      (tick),
    .irq_en    (cfg.irq_en),
    .wd_run    (wd_run),
    .wd_cnt    (wd_cnt),
    .wd_exp    (wd_exp),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
);

// File: tb/expiry_watchdog_tb_top.sv
module expiry_watchdog_tb_top;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TICK = 2'd2, OP_PINS = 2'd3;
    localparam logic [7:0] A_CFG = 8'h00, A_STS = 8'h04, A_CMD = 8'h08, A_KEY = 8'h0C, A_TMR = 8'h10;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int N_VEC = 60;
    localparam vec_t VEC [0:N_VEC-1] = '{
        '{OP_RD,   A_CFG, 32'h0,        32'h0,    4'd11}, // R11 reset state
        '{OP_RD,   A_STS, 32'h0,        32'h0,    4'd11},
        '{OP_PINS, A_CFG, 32'h0,        32'h0,    4'd11},
        '{OP_WR,   A_CFG, 32'hFFFFFFFF, 32'h0,    4'd1},
        '{OP_RD,   A_CFG, 32'h0,        32'h9FF0, 4'd1},  // R1 only fields kept
        '{OP_WR,   A_CFG, 32'h00009030, 32'h0,    4'd1},
        '{OP_RD,   A_CFG, 32'h0,        32'h9030, 4'd1},
        '{OP_WR,   A_CMD, 32'h1,        32'h0,    4'd3},
        '{OP_RD,   A_STS, 32'h0,        32'h0030, 4'd3},  // R3 start loads period
        '{OP_TICK, A_TMR, 32'd2,        32'h0,    4'd4},
        '{OP_RD,   A_STS, 32'h0,        32'h0010, 4'd4},  // R4 decrement
        '{OP_RD,   A_TMR, 32'h0,        32'h1,    4'd9},  // R9 single-shot clears enable
        '{OP_TICK, A_TMR, 32'd1,        32'h0,    4'd4},
        '{OP_RD,   A_STS, 32'h0,        32'h1030, 4'd2},  // R2 R4 first expiration
        '{OP_PINS, A_CFG, 32'h0,        32'h2,    4'd6},  // R6 irq high
        '{OP_TICK, A_TMR, 32'd3,        32'h0,    4'd4},
        '{OP_RD,   A_STS, 32'h0,        32'h2030, 4'd4},
        '{OP_TICK, A_TMR, 32'd3,        32'h0,    4'd4},
        '{OP_RD,   A_STS, 32'h0,        32'h3030, 4'd4},
        '{OP_TICK, A_TMR, 32'd2,        32'h0,    4'd7},
        '{OP_PINS, A_CFG, 32'h0,        32'h2,    4'd7},  // R7 not yet
        '{OP_TICK, A_TMR, 32'd1,        32'h0,    4'd7},
        '{OP_RD,   A_STS, 32'h0,        32'h0030, 4'd4},  // R4 wrap 3->0
        '{OP_PINS, A_CFG, 32'h0,        32'h3,    4'd7},  // R7 fourth expiration
        '{OP_WR,   A_CMD, 32'h1,        32'h0,    4'd3},
        '{OP_PINS, A_CFG, 32'h0,        32'h1,    4'd7},  // R3 irq clear, R7 sticky
        '{OP_RD,   A_STS, 32'h0,        32'h0030, 4'd3},
        '{OP_WR,   A_CMD, 32'h2,        32'h0,    4'd8},  // R8 stop without key
        '{OP_TICK, A_TMR, 32'd1,        32'h0,    4'd8},
        '{OP_RD,   A_STS, 32'h0,        32'h0020, 4'd8},
        '{OP_WR,   A_KEY, 32'h0000C45B, 32'h0,    4'd8},  // R8 wrong key
        '{OP_WR,   A_CMD, 32'h2,        32'h0,    4'd8},
        '{OP_TICK, A_TMR, 32'd1,        32'h0,    4'd8},
        '{OP_RD,   A_STS, 32'h0,        32'h0010, 4'd8},
        '{OP_WR,   A_KEY, 32'h0000C45A, 32'h0,    4'd8},  // R8 key then overwritten
        '{OP_WR,   A_KEY, 32'h00001234, 32'h0,    4'd8},
        '{OP_WR,   A_CMD, 32'h2,        32'h0,    4'd8},
        '{OP_TICK, A_TMR, 32'd1,        32'h0,    4'd8},
        '{OP_RD,   A_STS, 32'h0,        32'h1030, 4'd8},
        '{OP_PINS, A_CFG, 32'h0,        32'h3,    4'd6},
        '{OP_WR,   A_KEY, 32'h0000C45A, 32'h0,    4'd8},  // R8 key consumed by ping
        '{OP_WR,   A_CMD, 32'h1,        32'h0,    4'd3},
        '{OP_WR,   A_CMD, 32'h2,        32'h0,    4'd8},
        '{OP_TICK, A_TMR, 32'd1,        32'h0,    4'd8},
        '{OP_RD,   A_STS, 32'h0,        32'h0020, 4'd8},
        '{OP_TICK, A_TMR, 32'd2,        32'h0,    4'd6},
        '{OP_PINS, A_CFG, 32'h0,        32'h3,    4'd6},
        '{OP_WR,   A_KEY, 32'h0000C45A, 32'h0,    4'd8},  // R8 accepted stop
        '{OP_WR,   A_CMD, 32'h3,        32'h0,    4'd8},
        '{OP_PINS, A_CFG, 32'h0,        32'h1,    4'd6},  // R6 stop clears irq
        '{OP_TICK, A_TMR, 32'd3,        32'h0,    4'd8},
        '{OP_RD,   A_STS, 32'h0,        32'h1030, 4'd8},  // R8 frozen
        '{OP_WR,   A_CFG, 32'h00000000, 32'h0,    4'd5},
        '{OP_WR,   A_CMD, 32'h1,        32'h0,    4'd5},
        '{OP_RD,   A_STS, 32'h0,        32'h0010, 4'd5},  // R5 period 0 as 1
        '{OP_TICK, A_TMR, 32'd1,        32'h0,    4'd5},
        '{OP_RD,   A_STS, 32'h0,        32'h1010, 4'd5},
        '{OP_PINS, A_CFG, 32'h0,        32'h1,    4'd6},  // R6 no irq when disabled
        '{OP_TICK, A_TMR, 32'd1,        32'h0,    4'd5},
        '{OP_RD,   A_STS, 32'h0,        32'h2010, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        sel_slow = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_fast, rd_slow, rd_data;
    logic        irq_fast, irq_slow, rst_fast, rst_slow;
    logic [1:0]  pins;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    expiry_watchdog #(.CLK_PER_US(1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en && !sel_slow), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_fast),
        .irq_o(irq_fast), .rst_req_o(rst_fast)
    );

    expiry_watchdog #(.CLK_PER_US(3)) dut_slow_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en && sel_slow), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_slow),
        .irq_o(irq_slow), .rst_req_o(rst_slow)
    );

    assign rd_data = sel_slow ? rd_slow : rd_fast;
    assign pins    = sel_slow ? {irq_slow, rst_slow} : {irq_fast, rst_fast};

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [31:0] expv, input int req);
        rd_addr = a;
        #2;
        check(req, rd_data, expv);
        @(negedge clk);
    endtask

    task automatic do_pins(input logic [1:0] expv, input int req);
        #2;
        check(req, {30'h0, pins}, {30'h0, expv});
        @(negedge clk);
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            do_wr(A_TMR, 32'h80000001);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < N_VEC; v++) begin
            case (VEC[v].op)
                OP_WR:   do_wr(VEC[v].addr, VEC[v].data);
                OP_RD:   do_rd(VEC[v].addr, VEC[v].expv, int'(VEC[v].req));
                OP_TICK: do_tick(int'(VEC[v].data));
                default: do_pins(VEC[v].expv[1:0], int'(VEC[v].req));
            endcase
        end

        // R11 and R7: asynchronous reset clears the sticky request
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_pins(2'b00, 11);
        do_rd(A_CFG, 32'h0, 11);
        do_rd(A_TMR, 32'h0, 11);

        // R7: reset enable clear, four expirations give no request
        do_wr(A_CFG, 32'h00001010);
        do_wr(A_CMD, 32'h1);
        do_tick(4);
        do_pins(2'b10, 7);
        do_rd(A_STS, 32'h0010, 7);

        // R9: auto-reload, 8 ticks at period 2 reach the fourth expiration
        do_wr(A_CFG, 32'h00008020);
        do_wr(A_CMD, 32'h1);
        do_wr(A_TMR, 32'hC0000001);
        repeat (7) @(negedge clk);
        do_wr(A_TMR, 32'h0);
        do_pins(2'b01, 9);
        do_rd(A_STS, 32'h0020, 9);

        // R9: reload 3 gives the tick on the third strobe
        do_wr(A_CFG, 32'h00000050);
        do_wr(A_CMD, 32'h1);
        do_wr(A_TMR, 32'h80000003);
        repeat (2) @(negedge clk);
        do_rd(A_STS, 32'h0050, 9);
        do_rd(A_STS, 32'h0040, 9);

        // R10: prescaler of 3, thirty clocks of auto-reload give ten ticks
        sel_slow = 1'b1;
        do_wr(A_CFG, 32'h00000FF0);
        do_wr(A_CMD, 32'h1);
        do_wr(A_TMR, 32'hC0000001);
        repeat (29) @(negedge clk);
        do_wr(A_TMR, 32'h0);
        do_rd(A_STS, 32'h0F50, 10);
        sel_slow = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule